// File: doc/BRIEF.md
# Vector Length Control Unit

This block holds the vector length (VL) and maximum vector length (MVL) of a vector pipeline, and updates them from two decoded sources. The first is a 12-bit length-control field taken from a long prefixed instruction. That field can do one of four things: leave the state alone, load VL from a 1-offset immediate, load VL from a scalar register, or load both VL and MVL from one immediate in a single step. The second source is an explicit set-length operation. It sizes VL from a requested element count and from an allocation size given as an immediate.

Each accepted update can return the new VL to a scalar destination register through a write port. Encodings that are not allowed raise a one-cycle illegal-instruction flag and change nothing. The register file, instruction fetch and prefix extraction are outside the block: it sees only decoded fields and register read data. All outputs are registered, and the result of a request appears after the clock edge that samples it.

Top module: `vlen_ctrl`

## Requirements
- R1: During and after reset, VL = 1 and MVL = 1, with `wr_valid` = 0 and `illegal` = 0.
- R2: A prefix request with a field of all zeros leaves VL and MVL unchanged and issues no write.
- R3: A prefix field with bit 11 = 0, bits 5:0 = 0 and bits 10:6 nonzero is reserved. It pulses `illegal` for one cycle, leaves VL and MVL unchanged and issues no write.
- R4: A prefix field with bit 11 = 0 and bit 0 = 0 (and not all zeros) sets VL to bits 5:1 plus 1. MVL is unchanged.
- R5: A prefix field with bit 11 = 0 and bit 0 = 1 sets VL to `pfx_rdata`, the value of the register named by bits 5:1, saturated at XLEN. If bits 5:1 are 0, the request is illegal instead: `illegal` pulses and nothing changes.
- R6: A prefix field with bit 11 = 1 sets both VL and MVL to bits 5:0 plus 1.
- R7: A legal update whose destination index is nonzero raises `wr_valid` for exactly one cycle, with `wr_idx` = that index and `wr_data` = the new VL zero-extended. A destination index of 0 gives no write. For a prefix request the destination index is bits 10:6; for a set-length request it is `sv_dst_idx`. Results appear one clock after the request is sampled.
- R8: A set-length request whose immediate exceeds XLEN pulses `illegal` and changes nothing.
- R9: A set-length request with `sv_src_idx` = 0 sets VL to the immediate, which may be 0.
- R10: Otherwise a set-length request sets VL as follows: XLEN if `sv_rdata` is greater than twice the immediate; else `sv_rdata`/2 rounded down if `sv_rdata` is greater than the immediate; else `sv_rdata`.
- R11: A set-length request never changes MVL.
- R12: When both request strobes are high in one cycle, the prefix request is served and the set-length request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_valid | input | 1 | Prefix length-control request strobe |
| pfx_field | input | 12 | Length-control field of the prefixed instruction |
| pfx_rdata | input | XLEN | Value of the scalar register named by field bits 5:1 |
| sv_valid | input | 1 | Set-length request strobe |
| sv_src_idx | input | 5 | Source register index of the set-length request |
| sv_dst_idx | input | 5 | Destination register index of the set-length request |
| sv_imm | input | VLW | Allocation size immediate |
| sv_rdata | input | XLEN | Value of the source register |
| wr_valid | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | XLEN | New VL, zero-extended |
| illegal | output | 1 | Illegal-instruction pulse |
| vl | output | VLW | Current vector length |
| mvl | output | VLW | Current maximum vector length |

## Verification
The prefix path and the set-length path can both present a request in the same clock cycle. The bench provokes this with directed vectors and with random vectors where both strobes are high, mixing legal, reserved and out-of-range encodings on each side. It judges the result against a model in which the prefix request is served and the set-length request has no effect. That means it compares the write index, write data, illegal flag, VL and MVL, so a leaked set-length result or a stray illegal flag from the discarded side shows up as a miscompare.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // width of a scalar register index
  localparam int REG_W = 5;
  // width of the prefix length-control field
  localparam int FLD_W = 12;

  typedef enum logic [2:0] {
    LM_IDLE,
    LM_RSVD,
    LM_IMM,
    LM_REG,
    LM_BADREG,
    LM_BOTH
  } len_mode_e;
endpackage

// File: rtl/vlc_prefix_dec.sv
module vlc_prefix_dec
  import vlc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLW  = $clog2(XLEN + 1)
) (
  input  logic [FLD_W-1:0] fld,
  input  logic [XLEN-1:0]  rdata,
  output logic             upd_vl,
  output logic             upd_mvl,
  output logic [VLW-1:0]   new_vl,
  output logic [REG_W-1:0] dst_idx,
  output logic             bad
);
  localparam logic [XLEN-1:0] XMAX = XLEN'(XLEN);

  len_mode_e        mode;
  logic             one_shot;
  logic [REG_W-1:0] dst_f;
  logic [REG_W-1:0] len_f;
  logic             src_is_reg;

  assign one_shot   = fld[11];
  assign dst_f      = fld[10:6];
  assign len_f      = fld[5:1];
  assign src_is_reg = fld[0];
  assign dst_idx    = dst_f;

  function automatic logic [VLW-1:0] clip(input logic [XLEN-1:0] v);
    if (v > XMAX) return VLW'(XLEN);
    return v[VLW-1:0];
  endfunction

  always_comb begin
    if (fld == '0)                           mode = LM_IDLE;
    else if (one_shot)                       mode = LM_BOTH;
    else if (fld[5:0] == '0)                 mode = LM_RSVD;
    else if (!src_is_reg)                    mode = LM_IMM;
    else if (len_f == '0)                    mode = LM_BADREG;
    else                                     mode = LM_REG;
  end

  always_comb begin
    upd_vl  = 1'b0;
    upd_mvl = 1'b0;
    bad     = 1'b0;
    new_vl  = '0;
    unique case (mode)
      LM_IMM: begin
        upd_vl = 1'b1;
        new_vl = clip({{(XLEN-REG_W){1'b0}}, len_f} + XLEN'(1));
      end
      LM_REG: begin
        upd_vl = 1'b1;
        new_vl = clip(rdata);
      end
      LM_BOTH: begin
        upd_vl  = 1'b1;
        upd_mvl = 1'b1;
        new_vl  = clip({{(XLEN-6){1'b0}}, fld[5:0]} + XLEN'(1));
      end
      LM_RSVD, LM_BADREG: bad = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/vlc_setvl_calc.sv
module vlc_setvl_calc
  import vlc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLW  = $clog2(XLEN + 1)
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic [VLW-1:0]   imm,
  input  logic [XLEN-1:0]  rdata,
  output logic [VLW-1:0]   new_vl,
  output logic             bad
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] imm_dbl;

  assign imm_x   = XLEN'(imm);
  assign imm_dbl = {imm_x[XLEN-2:0], 1'b0};
  assign bad     = (imm > VL_MAX);

  always_comb begin
    if (src_idx == '0)          new_vl = imm;
    else if (rdata > imm_dbl)   new_vl = VL_MAX;
    else if (rdata > imm_x)     new_vl = rdata[VLW:1];
    else                        new_vl = rdata[VLW-1:0];
  end
endmodule

// File: rtl/vlc_state.sv
module vlc_state
  import vlc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLW  = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfx_valid,
  input  logic             pfx_upd_vl,
  input  logic             pfx_upd_mvl,
  input  logic [VLW-1:0]   pfx_vl,
  input  logic [REG_W-1:0] pfx_dst,
  input  logic             pfx_bad,
  input  logic             sv_valid,
  input  logic [VLW-1:0]   sv_vl,
  input  logic [REG_W-1:0] sv_dst,
  input  logic             sv_bad,
  output logic             wr_valid,
  output logic [REG_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             illegal,
  output logic [VLW-1:0]   vl,
  output logic [VLW-1:0]   mvl
);
  localparam logic [VLW-1:0] VL_ONE = VLW'(1);
  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);

  logic             sel_upd;
  logic             sel_mvl;
  logic             sel_bad;
  logic [VLW-1:0]   sel_vl;
  logic [REG_W-1:0] sel_dst;

  // prefix request wins over a set-length request in the same cycle
  always_comb begin
    if (pfx_valid) begin
      sel_upd = pfx_upd_vl;
      sel_mvl = pfx_upd_mvl;
      sel_bad = pfx_bad;
      sel_vl  = pfx_vl;
      sel_dst = pfx_dst;
    end else begin
      sel_upd = sv_valid && !sv_bad;
      sel_mvl = 1'b0;
      sel_bad = sv_valid && sv_bad;
      sel_vl  = sv_vl;
      sel_dst = sv_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl       <= VL_ONE;
      mvl      <= VL_ONE;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      illegal  <= 1'b0;
    end else begin
      illegal  <= sel_bad;
      wr_valid <= sel_upd && (sel_dst != '0);
      wr_idx   <= sel_dst;
      wr_data  <= {{(XLEN-VLW){1'b0}}, sel_vl};
      if (sel_upd) vl <= sel_vl;
      if (sel_upd && sel_mvl) mvl <= sel_vl;
    end
  end

  // R3 R5 R8
  property p_bad_freezes;
    @(posedge clk) disable iff (rst)
      illegal |-> (vl == $past(vl)) && (mvl == $past(mvl)) && !wr_valid;
  endproperty
  illegal_freeze_chk: assert property (p_bad_freezes);

  // R7
  property p_wr_matches_vl;
    @(posedge clk) disable iff (rst)
      wr_valid |-> (wr_data == {{(XLEN-VLW){1'b0}}, vl}) && (wr_idx != '0);
  endproperty
  wr_data_vl_chk: assert property (p_wr_matches_vl);

  // R6
  property p_both_equal;
    @(posedge clk) disable iff (rst)
      $past(pfx_valid && pfx_upd_mvl) |-> (vl == mvl);
  endproperty
  one_shot_pair_chk: assert property (p_both_equal);

  // R11
  property p_mvl_only_oneshot;
    @(posedge clk) disable iff (rst)
      !$past(pfx_valid && pfx_upd_mvl) |-> $stable(mvl);
  endproperty
  mvl_hold_chk: assert property (p_mvl_only_oneshot);

  // R5 R10
  property p_vl_range;
    @(posedge clk) disable iff (rst)
      (vl <= VL_MAX) && (mvl <= VL_MAX) && (mvl != '0);
  endproperty
  vl_range_chk: assert property (p_vl_range);
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLW  = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfx_valid,
  input  logic [FLD_W-1:0] pfx_field,
  input  logic [XLEN-1:0]  pfx_rdata,
  input  logic             sv_valid,
  input  logic [REG_W-1:0] sv_src_idx,
  input  logic [REG_W-1:0] sv_dst_idx,
  input  logic [VLW-1:0]   sv_imm,
  input  logic [XLEN-1:0]  sv_rdata,
  output logic             wr_valid,
  output logic [REG_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             illegal,
  output logic [VLW-1:0]   vl,
  output logic [VLW-1:0]   mvl
);
  logic             p_upd_vl;
  logic             p_upd_mvl;
  logic [VLW-1:0]   p_vl;
  logic [REG_W-1:0] p_dst;
  logic             p_bad;
  logic [VLW-1:0]   s_vl;
  logic             s_bad;

  vlc_prefix_dec #(.XLEN(XLEN), .VLW(VLW)) u_dec (
    .fld     (pfx_field),
    .rdata   (pfx_rdata),
    .upd_vl  (p_upd_vl),
    .upd_mvl (p_upd_mvl),
    .new_vl  (p_vl),
    .dst_idx (p_dst),
    .bad     (p_bad)
  );

  vlc_setvl_calc #(.XLEN(XLEN), .VLW(VLW)) u_calc (
    .src_idx (sv_src_idx),
    .imm     (sv_imm),
    .rdata   (sv_rdata),
    .new_vl  (s_vl),
    .bad     (s_bad)
  );

  vlc_state #(.XLEN(XLEN), .VLW(VLW)) u_state (
    .clk         (clk),
    .rst         (rst),
    .pfx_valid   (pfx_valid),
    .pfx_upd_vl  (p_upd_vl),
    .pfx_upd_mvl (p_upd_mvl),
    .pfx_vl      (p_vl),
    .pfx_dst     (p_dst),
    .pfx_bad     (p_bad),
    .sv_valid    (sv_valid),
    .sv_vl       (s_vl),
    .sv_dst      (sv_dst_idx),
    .sv_bad      (s_bad),
    .wr_valid    (wr_valid),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .illegal     (illegal),
    .vl          (vl),
    .mvl         (mvl)
  );
endmodule

// File: tb/vlen_ctrl_tb_top.sv
`timescale 1ns/1ps
module vlen_ctrl_tb_top;
  localparam int XLEN = 64;
  localparam int VLW  = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            pfx_valid = 1'b0;
  logic [11:0]     pfx_field = '0;
  logic [XLEN-1:0] pfx_rdata = '0;
  logic            sv_valid = 1'b0;
  logic [4:0]      sv_src_idx = '0;
  logic [4:0]      sv_dst_idx = '0;
  logic [VLW-1:0]  sv_imm = '0;
  logic [XLEN-1:0] sv_rdata = '0;
  logic            wr_valid;
  logic [4:0]      wr_idx;
  logic [XLEN-1:0] wr_data;
  logic            illegal;
  logic [VLW-1:0]  vl;
  logic [VLW-1:0]  mvl;

  int n_chk = 0;
  int n_bad = 0;

  longint unsigned e_vl = 1, e_mvl = 1, e_wd = 0;
  bit              e_wv = 0, e_ill = 0;
  int unsigned     e_wi = 0;
  string           tag;

  always #5 clk = ~clk;

  vlen_ctrl #(.XLEN(XLEN), .VLW(VLW)) dut_i (
    .clk(clk), .rst(rst),
    .pfx_valid(pfx_valid), .pfx_field(pfx_field), .pfx_rdata(pfx_rdata),
    .sv_valid(sv_valid), .sv_src_idx(sv_src_idx), .sv_dst_idx(sv_dst_idx),
    .sv_imm(sv_imm), .sv_rdata(sv_rdata),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .illegal(illegal), .vl(vl), .mvl(mvl)
  );

  task automatic chk(input string t, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input bit both, input int dst,
                                     input int len, input bit isreg);
    return {both, 5'(dst), 5'(len), isreg};
  endfunction

  // reference model from the requirements
  task automatic model();
    longint unsigned nv, r, im;
    bit upd, setm;
    int unsigned d;
    upd = 0; setm = 0; nv = 0; d = 0;
    e_ill = 0; e_wv = 0; e_wi = 0; e_wd = 0; tag = "R2";
    if (pfx_valid) begin
      d = pfx_field[10:6];
      if (pfx_field == 0) tag = "R2";
      else if (pfx_field[11]) begin
        tag = "R6"; upd = 1; setm = 1; nv = longint'(pfx_field[5:0]) + 1;
      end else if (pfx_field[5:0] == 0) begin
        tag = "R3"; e_ill = 1;
      end else if (!pfx_field[0]) begin
        tag = "R4"; upd = 1; nv = longint'(pfx_field[5:1]) + 1;
      end else if (pfx_field[5:1] == 0) begin
        tag = "R5"; e_ill = 1;
      end else begin
        tag = "R5"; upd = 1; r = pfx_rdata; nv = (r > XLEN) ? XLEN : r;
      end
      if (sv_valid) tag = {tag, "/R12"};
    end else if (sv_valid) begin
      d = sv_dst_idx; im = sv_imm; r = sv_rdata;
      if (im > XLEN) begin tag = "R8"; e_ill = 1; end
      else if (sv_src_idx == 0) begin tag = "R9"; upd = 1; nv = im; end
      else begin
        tag = "R10/R11"; upd = 1;
        if (r > 2 * im) nv = XLEN;
        else if (r > im) nv = r / 2;
        else nv = r;
      end
    end
    if (upd) begin
      e_vl = nv;
      if (setm) e_mvl = nv;
      if (d != 0) begin e_wv = 1; e_wi = d; e_wd = nv; end
    end
  endtask

  // inputs already set at a negedge; sample one cycle later at the next negedge
  task automatic apply();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "vl", vl, e_vl);
    chk(tag, "mvl", mvl, e_mvl);
    chk(tag, "illegal", illegal, e_ill);
    chk({tag, "/R7"}, "wr_valid", wr_valid, e_wv);
    if (e_wv) begin
      chk({tag, "/R7"}, "wr_idx", wr_idx, e_wi);
      chk({tag, "/R7"}, "wr_data", wr_data, e_wd);
    end
    pfx_valid = 0; sv_valid = 0;
  endtask

  task automatic pfx(input logic [11:0] f, input longint unsigned rd);
    pfx_valid = 1; pfx_field = f; pfx_rdata = rd; apply();
  endtask

  task automatic svl(input int s, input int d, input int im, input longint unsigned rd);
    sv_valid = 1; sv_src_idx = 5'(s); sv_dst_idx = 5'(d);
    sv_imm = VLW'(im); sv_rdata = rd; apply();
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog timeout");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "vl", vl, 1);
    chk("R1", "mvl", mvl, 1);
    chk("R1", "wr_valid", wr_valid, 0);
    chk("R1", "illegal", illegal, 0);
    rst = 0;

    pfx(12'h000, 0);                 // R2
    pfx(mk(1, 4, 19, 1), 0);         // R6 VL=MVL=40, write x4
    pfx(mk(0, 3, 0, 0), 0);          // R3 reserved
    pfx(mk(0, 0, 0, 0) | 12'h002, 0);// R4 len=1 -> 2, no write
    pfx(mk(0, 0, 0, 0) | 12'h000, 0);// R2 again
    pfx(mk(0, 5, 31, 0), 0);         // R4 -> 32, write x5
    pfx(mk(0, 2, 7, 1), 40);         // R5 reg -> 40
    pfx(mk(0, 2, 7, 1), 1000);       // R5 saturate -> 64
    pfx(mk(0, 2, 0, 1), 9);          // R5 x0 illegal
    pfx(mk(1, 1, 31, 1), 0);         // R6 -> 64/64
    pfx(mk(1, 0, 0, 0), 0);          // R6 -> 1/1
    svl(0, 6, 65, 0);                // R8
    svl(0, 6, 64, 0);                // R9 -> 64
    svl(0, 0, 0, 0);                 // R9 -> 0
    svl(3, 7, 10, 25);               // R10 -> 64
    svl(3, 7, 10, 20);               // R10 -> 10
    svl(3, 7, 10, 11);               // R10 -> 5
    svl(3, 7, 10, 10);               // R10 -> 10
    svl(3, 7, 10, 0);                // R10 -> 0
    // R12 both at once
    pfx_valid = 1; pfx_field = mk(0, 9, 3, 0);
    sv_valid = 1; sv_src_idx = 0; sv_dst_idx = 8; sv_imm = 50; apply();
    pfx_valid = 1; pfx_field = mk(0, 9, 0, 0);
    sv_valid = 1; sv_src_idx = 0; sv_dst_idx = 8; sv_imm = 50; apply();
    pfx_valid = 1; pfx_field = 12'h000;
    sv_valid = 1; sv_src_idx = 0; sv_dst_idx = 8; sv_imm = 90; apply();

    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      k = $urandom % 8;
      pfx_valid = (k < 4) || (k == 6);
      sv_valid  = (k >= 3) && (k < 7);
      case ($urandom % 4)
        0: pfx_field = 12'($urandom) & 12'h7C0;
        1: pfx_field = 12'($urandom) & 12'hFC1;
        default: pfx_field = 12'($urandom);
      endcase
      pfx_rdata  = ($urandom % 2) ? 64'($urandom % 80) : {$urandom, $urandom};
      sv_src_idx = 5'($urandom % 4);
      sv_dst_idx = 5'($urandom);
      sv_imm     = VLW'($urandom % 72);
      sv_rdata   = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 160);
      apply();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule